// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial-port slave that gives a host access to a small bank of 8-bit configuration registers. The serial clock is its only clock. A low level on the active-low select frames each transaction. The first byte of a transaction is an instruction that holds the transfer direction, a byte count and a register address. One to four data bytes follow. Each data byte is either shifted into the addressed register or shifted out of it.

Register 0 holds two mode bits. Bit 6 sets the bit order, which applies to both instruction and data bytes. Bit 7 sets the pin mode: in 4-wire mode read data leaves on a dedicated output, and in 3-wire mode it is driven back on the data input pin. Either setting takes effect as soon as the eighth bit of register 0 has been shifted in, even in the middle of a multibyte write. In a multibyte transfer the address steps after each byte. It counts down from a final address when most-significant-bit-first order is in force, and counts up from a start address when least-significant-bit-first order is in force. The tri-state pins are modelled as separate data and output-enable ports.

Top module: `spi_regport`

## Requirements
- R1: The first eight rising `sclk` edges after `cs_n` falls form the instruction byte. Bit 7 = 1 means read and 0 means write. Bits 6:5 give the count, where value n transfers n+1 bytes. Bits 4:0 give the register address.
- R2: On a write, each data byte is built from `sdio_in` sampled on rising `sclk` edges. It is stored into the addressed register on the eighth rising edge of that byte.
- R3: On a read, the first data bit appears on the falling edge straight after the eighth instruction rising edge, with its output enable high. Each following bit appears on the next falling edge.
- R4: Register 0 bit 6 sets the bit order. 0 means bit 7 first, down to bit 0. 1 means bit 0 first, up to bit 7. The order applies to instruction bytes and to data bytes, in both directions.
- R5: Multibyte transfers step the address by one after each byte, modulo 32. The address decrements when bit 6 of register 0 is 0 at instruction decode and increments when it is 1. The direction stays fixed for the rest of the transaction.
- R6: Register 0 bit 7 sets the pin mode. 0 means 4-wire: read data is on `sdo` with `sdo_oe`=1 and `sdio_oe`=0. 1 means 3-wire: read data is on `sdio_out` with `sdio_oe`=1 and `sdo_oe`=0.
- R7: A new register 0 value governs the bit order and pin mode from the bit that follows its eighth bit, including the later bytes of the same transfer.
- R8: If `cs_n` rises in the middle of a byte, that partial byte is discarded. Bytes that were already complete stay written, and no further register changes.
- R9: While `cs_n` is high, both `sdo_oe` and `sdio_oe` are 0. The two enables are never high together.
- R10: Addresses at or above NREG (default 8) are not implemented. Writes to them change no register, and reads from them return 0x00.
- R11: A high `rst` sampled on a rising `sclk` edge clears every register to 0x00, which selects bit-7-first order and 4-wire mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; inputs are sampled on the rising edge and outputs change on the falling edge |
| rst | input | 1 | Synchronous active-high reset, sampled on the rising `sclk` edge |
| cs_n | input | 1 | Active-low transaction frame |
| sdio_in | input | 1 | Serial data into the block |
| sdio_out | output | 1 | Read data driven on the shared pin in 3-wire mode |
| sdio_oe | output | 1 | Drive enable for the shared data pin |
| sdo | output | 1 | Read data for the dedicated output pin in 4-wire mode |
| sdo_oe | output | 1 | Drive enable for the dedicated output pin |

## Verification
A sweep writes an address-derived pattern to all 32 addresses and then reads each one back. This separates stored registers from unimplemented ones and exposes any aliasing between them. Multibyte transfers are run with both bit orders, including a start address that crosses the end of the bank and one that wraps from 31 to 0. These show whether the address counts down or up and whether the bits within each byte are reversed. Further transactions flip register 0 in the middle of a write and abort a transfer partway through a byte. They tell an immediate mode switch apart from a deferred one, and a discarded partial byte apart from a committed one. Reads in 3-wire mode check that the data and its enable are routed to the right pin.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;
  localparam int CNT_W  = 2;
  localparam int BIT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } phase_t;
endpackage

// File: rtl/spi_rx_engine.sv
module spi_rx_engine
  import spi_regport_pkg::*;
(
  input  logic              sclk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              din,
  input  logic              lsb_first,
  output phase_t            phase,
  output logic              is_read,
  output logic [BIT_W-1:0]  bit_cnt,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              we,
  output logic [BYTE_W-1:0] wdata,
  output logic              read_start
);
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] byte_nxt;
  logic [CNT_W-1:0]  left;
  logic              step_up;
  logic              last_bit;

  // The incoming bit enters at the end that matches the current bit order.
  always_comb begin
    if (lsb_first) byte_nxt = {din, shreg[BYTE_W-1:1]};
    else           byte_nxt = {shreg[BYTE_W-2:0], din};
  end

  assign last_bit   = (bit_cnt == BIT_W'(BYTE_W - 1));
  assign we         = !cs_n && (phase == PH_DATA) && !is_read && last_bit;
  assign wdata      = byte_nxt;
  assign read_start = !cs_n && (phase == PH_INSTR) && last_bit && byte_nxt[BYTE_W-1];

  // A high cs_n clears the transaction state at once, which discards any partial byte.
  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      phase    <= PH_INSTR;
      is_read  <= 1'b0;
      left     <= '0;
      cur_addr <= '0;
      step_up  <= 1'b0;
    end else if (rst) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      phase    <= PH_INSTR;
      is_read  <= 1'b0;
      left     <= '0;
      cur_addr <= '0;
      step_up  <= 1'b0;
    end else begin
      shreg   <= byte_nxt;
      bit_cnt <= bit_cnt + 1'b1;
      if (last_bit) begin
        case (phase)
          PH_INSTR: begin
            is_read  <= byte_nxt[7];
            left     <= byte_nxt[6:5];
            cur_addr <= byte_nxt[ADDR_W-1:0];
            step_up  <= lsb_first;
            phase    <= PH_DATA;
          end
          PH_DATA: begin
            if (left == '0) begin
              phase <= PH_DONE;
            end else begin
              left     <= left - 1'b1;
              cur_addr <= step_up ? cur_addr + 1'b1 : cur_addr - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: a completed instruction byte always moves the engine into the data phase
  a_r1_instr_to_data: assert property (@(posedge sclk) disable iff (rst || cs_n)
    (phase == PH_INSTR && last_bit) |=> (phase == PH_DATA && bit_cnt == '0));

  // R5: between bytes the address moves by one in the direction latched at decode
  a_r5_addr_step: assert property (@(posedge sclk) disable iff (rst || cs_n)
    (phase == PH_DATA && last_bit && left != '0) |=>
      (cur_addr == (step_up ? ADDR_W'($past(cur_addr) + 1'b1)
                            : ADDR_W'($past(cur_addr) - 1'b1))));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regport_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic              sclk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [BYTE_W-1:0] rdata,
  output logic              lsb_first,
  output logic              wire3
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [BYTE_W-1:0] mem [NREG];

  // Each register is its own flop group, so reset clears all of them and register 0 feeds the mode bits directly.
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge sclk) begin
      if (rst)                                    mem[i] <= '0;
      else if (we && waddr == ADDR_W'(i))         mem[i] <= wdata;
    end

    // R10: a register changes only when its own address is written
    a_r10_untouched: assert property (@(posedge sclk) disable iff (rst)
      (!we || waddr != ADDR_W'(i)) |=> $stable(mem[i]));
  end

  always_comb begin
    if (raddr < ADDR_W'(NREG)) rdata = mem[raddr[IDX_W-1:0]];
    else                       rdata = '0;
  end

  assign lsb_first = mem[0][6];
  assign wire3     = mem[0][7];

  // R7: a write to register 0 changes the mode bits on the very next edge
  a_r7_mode_now: assert property (@(posedge sclk) disable iff (rst)
    (we && waddr == '0) |=> ({wire3, lsb_first} == $past(wdata[7:6])));

  // R11: reset returns to bit-7-first, 4-wire operation
  a_r11_reset_mode: assert property (@(posedge sclk)
    rst |=> (!lsb_first && !wire3));
endmodule

// File: rtl/spi_tx_driver.sv
module spi_tx_driver
  import spi_regport_pkg::*;
(
  input  logic              sclk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              active,
  input  logic [BIT_W-1:0]  bit_cnt,
  input  logic              lsb_first,
  input  logic              wire3,
  input  logic [BYTE_W-1:0] rdata,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              sdio_out,
  output logic              sdio_oe
);
  logic bit_sel;

  always_comb begin
    if (lsb_first) bit_sel = rdata[bit_cnt];
    else           bit_sel = rdata[BIT_W'(BYTE_W - 1) - bit_cnt];
  end

  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
      sdio_out <= 1'b0;
      sdio_oe  <= 1'b0;
    end else begin
      sdo      <= bit_sel;
      sdio_out <= bit_sel;
      sdo_oe   <= active && !wire3;
      sdio_oe  <= active && wire3;
    end
  end

  // R9: only one pin is driven at any time
  a_r9_one_driver: assert property (@(posedge sclk) disable iff (rst)
    !(sdo_oe && sdio_oe));

  // R9: an idle frame leaves both pins released
  a_r9_idle_released: assert property (@(posedge sclk) disable iff (rst)
    cs_n |-> (!sdo_oe && !sdio_oe));
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic sclk,
  input  logic rst,
  input  logic cs_n,
  input  logic sdio_in,
  output logic sdio_out,
  output logic sdio_oe,
  output logic sdo,
  output logic sdo_oe
);
  phase_t            phase;
  logic              is_read;
  logic [BIT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] cur_addr;
  logic              we;
  logic [BYTE_W-1:0] wdata;
  logic              read_start;
  logic [BYTE_W-1:0] rdata;
  logic              lsb_first;
  logic              wire3;

  spi_rx_engine u_rx (
    .sclk       (sclk),
    .rst        (rst),
    .cs_n       (cs_n),
    .din        (sdio_in),
    .lsb_first  (lsb_first),
    .phase      (phase),
    .is_read    (is_read),
    .bit_cnt    (bit_cnt),
    .cur_addr   (cur_addr),
    .we         (we),
    .wdata      (wdata),
    .read_start (read_start)
  );

  spi_reg_bank #(.NREG(NREG)) u_bank (
    .sclk      (sclk),
    .rst       (rst),
    .we        (we),
    .waddr     (cur_addr),
    .wdata     (wdata),
    .raddr     (cur_addr),
    .rdata     (rdata),
    .lsb_first (lsb_first),
    .wire3     (wire3)
  );

  spi_tx_driver u_tx (
    .sclk      (sclk),
    .rst       (rst),
    .cs_n      (cs_n),
    .active    (phase == PH_DATA && is_read),
    .bit_cnt   (bit_cnt),
    .lsb_first (lsb_first),
    .wire3     (wire3),
    .rdata     (rdata),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .sdio_out  (sdio_out),
    .sdio_oe   (sdio_oe)
  );

  // R3: a read instruction gives a driven pin by the next rising edge
  a_r3_first_bit: assert property (@(posedge sclk) disable iff (rst || cs_n)
    read_start |=> (sdo_oe || sdio_oe));
endmodule

// File: tb/test_spi_regport.sv
module test_spi_regport;
  localparam int NREG = 8;

  logic sclk = 1'b0;
  logic rst  = 1'b1;
  logic cs_n = 1'b1;
  logic sdio_in = 1'b0;
  logic sdio_out, sdio_oe, sdo, sdo_oe;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [7:0] mreg [32];
  bit m_lsb = 1'b0;
  bit m_wire3 = 1'b0;

  always #10 sclk = ~sclk;

  spi_regport #(.NREG(NREG)) i_spi_regport (
    .sclk(sclk), .rst(rst), .cs_n(cs_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [4:0] a, input logic [7:0] d);
    if (a < NREG) mreg[a] = d;
    if (a == 5'd0) begin
      m_lsb   = d[6];
      m_wire3 = d[7];
    end
  endtask

  function automatic logic [7:0] model_read(input logic [4:0] a);
    return (a < NREG) ? mreg[a] : 8'h00;
  endfunction

  task automatic put_bit(input logic b);
    @(negedge sclk);
    cs_n = 1'b0;
    sdio_in = b;
  endtask

  task automatic put_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) put_bit(m_lsb ? b[i] : b[7-i]);
  endtask

  task automatic end_frame();
    @(negedge sclk);
    cs_n = 1'b1;
    @(negedge sclk);
  endtask

  // Full transaction: len is the count field (bytes = len+1).
  task automatic xact(input string req, input bit rw, input logic [1:0] len,
                      input logic [4:0] addr, input logic [31:0] wd);
    logic [4:0] a;
    bit up;
    put_byte({rw, len, addr});
    up = m_lsb;
    a = addr;
    for (int k = 0; k <= int'(len); k++) begin
      if (!rw) begin
        put_byte(wd[8*k +: 8]);
        model_write(a, wd[8*k +: 8]);
      end else begin
        logic [7:0] got;
        bit oe_ok;
        oe_ok = 1'b1;
        got = '0;
        for (int i = 0; i < 8; i++) begin
          logic bv;
          @(negedge sclk);
          #5;
          bv = m_wire3 ? sdio_out : sdo;
          if (m_wire3) oe_ok = oe_ok && sdio_oe && !sdo_oe;
          else         oe_ok = oe_ok && sdo_oe && !sdio_oe;
          if (m_lsb) got[i] = bv; else got[7-i] = bv;
        end
        chk({req, " data"}, {24'h0, got}, {24'h0, model_read(a)});
        chk({req, " R6 R3 output enables"}, {31'h0, oe_ok}, 32'h1);
      end
      a = up ? a + 5'd1 : a - 5'd1;
    end
    end_frame();
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 29 + 7) ^ 8'hA5;
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) mreg[i] = 8'h00;
    repeat (3) @(negedge sclk);
    rst = 1'b0;
    @(negedge sclk);
    #5;
    chk("R9 idle sdo_oe", {31'h0, sdo_oe}, 32'h0);
    chk("R9 idle sdio_oe", {31'h0, sdio_oe}, 32'h0);
    for (int a = 0; a < NREG; a++) xact("R11 reset value", 1'b1, 2'd0, 5'(a), 32'h0);

    // R2 / R10: sweep every address, then read all back
    for (int a = 0; a < 32; a++)
      xact("R2 write", 1'b0, 2'd0, 5'(a), {24'h0, (a == 0) ? (pat(a) & 8'h3F) : pat(a)});
    for (int a = 0; a < 32; a++)
      xact((a < NREG) ? "R2 readback" : "R10 unimplemented", 1'b1, 2'd0, 5'(a), 32'h0);

    // R5 / R1: MSB-first multibyte counts down from final address 7
    xact("R5 down write", 1'b0, 2'd3, 5'd7, 32'h44332211);
    xact("R5 down read", 1'b1, 2'd3, 5'd7, 32'h0);
    xact("R5 single 4", 1'b1, 2'd0, 5'd4, 32'h0);

    // R4: switch to LSB-first with a single-byte write
    xact("R4 set lsb", 1'b0, 2'd0, 5'd0, 32'h00000040);
    xact("R4 lsb write", 1'b0, 2'd2, 5'd2, 32'h00C3B2A1);
    xact("R4 R5 up read", 1'b1, 2'd2, 5'd2, 32'h0);
    xact("R5 R10 up across end", 1'b1, 2'd3, 5'd6, 32'h0);
    xact("R5 wrap 31 to 0", 1'b1, 2'd1, 5'd31, 32'h0);

    // R6: 3-wire reads with LSB order
    xact("R6 set 3wire", 1'b0, 2'd0, 5'd0, 32'h000000C0);
    xact("R6 3wire read", 1'b1, 2'd2, 5'd1, 32'h0);
    xact("R6 back 4wire", 1'b0, 2'd0, 5'd0, 32'h00000000);
    xact("R6 4wire read", 1'b1, 2'd0, 5'd0, 32'h0);

    // R7: mid-transfer order switch, LSB -> MSB between bytes
    xact("R7 set lsb", 1'b0, 2'd0, 5'd0, 32'h00000040);
    xact("R7 mid switch", 1'b0, 2'd1, 5'd0, 32'h00009C00);
    xact("R7 reg1 readback", 1'b1, 2'd0, 5'd1, 32'h0);
    chk("R7 model reg1", {24'h0, mreg[1]}, 32'h9C);

    // R8: abort after 5 data bits of a single write to 3
    put_byte({1'b0, 2'd0, 5'd3});
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    end_frame();
    xact("R8 partial discarded", 1'b1, 2'd0, 5'd3, 32'h0);

    // R8: two-byte write to 5 then 4, abort in the second byte
    put_byte({1'b0, 2'd1, 5'd5});
    put_byte(8'hE1);
    model_write(5'd5, 8'hE1);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    end_frame();
    xact("R8 first byte kept", 1'b1, 2'd0, 5'd5, 32'h0);
    xact("R8 second byte dropped", 1'b1, 2'd0, 5'd4, 32'h0);

    // R9: abort a read partway, enables drop with cs_n
    put_byte({1'b1, 2'd1, 5'd6});
    repeat (3) @(negedge sclk);
    #5;
    chk("R9 driving during read", {31'h0, sdo_oe}, 32'h1);
    @(negedge sclk);
    cs_n = 1'b1;
    #5;
    chk("R9 released sdo_oe", {31'h0, sdo_oe}, 32'h0);
    chk("R9 released sdio_oe", {31'h0, sdio_oe}, 32'h0);
    @(negedge sclk);

    // R11: reset while LSB 3-wire mode is active
    xact("R11 set mode", 1'b0, 2'd0, 5'd0, 32'h000000C0);
    rst = 1'b1;
    repeat (2) @(negedge sclk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) mreg[i] = 8'h00;
    m_lsb = 1'b0;
    m_wire3 = 1'b0;
    xact("R11 reg0 cleared", 1'b1, 2'd0, 5'd0, 32'h0);
    xact("R11 reg2 cleared", 1'b1, 2'd0, 5'd2, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge sclk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule